// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block sits between a processor load/store port and a slower, word-addressed backing memory. It keeps a direct-mapped array of lines, each holding a block of four 32-bit words together with a tag and a valid flag. A load that finds its line present returns the cached word in the same cycle. A load that misses holds the requester stalled while the controller reads the whole block from memory, lowest word first. It then marks the line valid and completes the load from the cache.

Stores are written through. Each accepted store enters a small posted buffer, which drains to memory in arrival order whenever the memory port is not busy with a refill. A store that finds its line present also updates the cached word. A store that misses leaves the cache untouched. The requester is held only when the buffer has no free slot. Loads search the buffer, and the youngest buffered copy of a word takes precedence over any other source. A refill never reads a block while the buffer still holds a store for that block.

The requester keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. An access completes on a rising edge where `cpu_req` is high and `cpu_stall` is low, and load data on `cpu_rdata` is valid in that cycle. A memory transfer completes on a rising edge where `mem_req` and `mem_ready` are both high. Read data on `mem_rdata` is sampled at that edge.

Top module: `wtc_cache_ctrl`

## Requirements
- R1: A byte address splits into byte offset [1:0], word-in-block [3:2], line index in the next log2(LINES) bits, and tag in all remaining upper bits. Two blocks with the same index but different tags evict each other. Blocks with different indices do not.
- R2: A load to a valid line whose stored tag equals the address tag completes in the cycle it is presented, without stall, and returns the current value of that word.
- R3: A load that neither hits a line nor matches a buffered store stalls the requester until the refilled line can serve it.
- R4: A refill reads every word of the block from memory, with word-in-block 0, 1, 2, 3 in that order. The line serves loads only after the last word has arrived, so later loads to any word of the block hit.
- R5: Every accepted store is presented to memory exactly once with `mem_we` high, carrying its word address and data, in the order the stores were accepted.
- R6: With memory not accepting transfers, WB_DEPTH stores are accepted without stall. A further store stalls until a slot frees.
- R7: A load whose word address matches a buffered store completes without stall and returns the data of the youngest such store.
- R8: A store that hits updates the cached word, so a later hit returns the new value. A store that misses allocates no line, so a later load to another word of that block misses and stalls.
- R9: No refill read is issued while the buffer holds a store whose address lies in the block being refilled.
- R10: After reset all lines are invalid, the buffer is empty, and `mem_req` and `cpu_stall` are low with no request pending.
- R11: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Requester access valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Requester must hold its access |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer, 0 = refill read |
| mem_addr | output | 30 | Word address of the transfer |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for the current read transfer |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |

## Verification
The bench builds the block with 8 lines, a 4-entry buffer and 4-word blocks. Its traffic is confined to a 1 KiB window, so each index is shared by eight tags and conflict evictions, store misses and loads that land on pending stores happen often. With a 4-entry buffer, a short burst of stores against a memory that refuses transfers reaches the full-buffer stall within a few accesses. The four-word block keeps refill ordering and block-conflict waits visible at every fill.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BYTE_OFF_W = 2;
    localparam int WADDR_W    = ADDR_W - BYTE_OFF_W;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef struct packed {
        waddr_t waddr;
        word_t  data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DRAIN = 2'd1,
        FS_FILL  = 2'd2
    } fill_state_t;

    function automatic waddr_t word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BYTE_OFF_W];
    endfunction

    function automatic logic same_block(input waddr_t a, input waddr_t b, input int off_w);
        return (a >> off_w) == (b >> off_w);
    endfunction

endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
    import wtc_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int BLK_WORDS = 4,
    parameter int TAG_W     = 25
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(LINES)-1:0]      lk_idx,
    input  logic [$clog2(BLK_WORDS)-1:0]  lk_word,
    input  logic [TAG_W-1:0]              lk_tag,
    output logic                          lk_hit,
    output word_t                         lk_data,
    input  logic                          wr_en,
    input  logic [$clog2(LINES)-1:0]      wr_idx,
    input  logic [$clog2(BLK_WORDS)-1:0]  wr_word,
    input  word_t                         wr_data,
    input  logic                          inv_en,
    input  logic                          val_en,
    input  logic [$clog2(LINES)-1:0]      ln_idx,
    input  logic [TAG_W-1:0]              val_tag
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int SLOTS = LINES * BLK_WORDS;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    word_t            data_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inv_en) begin
            valid_q[ln_idx] <= 1'b0;
        end else if (val_en) begin
            valid_q[ln_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (val_en) begin
            tag_q[ln_idx] <= val_tag;
        end
        if (wr_en) begin
            data_q[{wr_idx, wr_word}] <= wr_data;
        end
    end

    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_data = data_q[{lk_idx, lk_word}];
    end

    // R4: a line is never cleared and validated in the same cycle
    a_r4_inv_val_apart: assert property (@(posedge clk) disable iff (rst)
        inv_en |-> !val_en);

    // R10: the valid flags come out of reset cleared
    a_r10_cold_lines: assert property (@(posedge clk)
        $fell(rst) |-> (valid_q == '0));

    logic unused_w;
    assign unused_w = ^{IDX_W, OFF_W};

endmodule

// File: rtl/wtc_write_buffer.sv
module wtc_write_buffer
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OFF_W = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_entry,
    input  logic      pop,
    output wb_entry_t head,
    output logic      empty,
    output logic      full,
    input  waddr_t    snp_waddr,
    output logic      snp_hit,
    output word_t     snp_data,
    output logic      blk_busy
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_entry_t         slot_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [CNT_W-1:0]  count_q;

    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));
    assign head  = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr_q] <= push_entry;
        end
    end

    // Scan oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        logic [PTR_W-1:0] slot;
        snp_hit  = 1'b0;
        snp_data = '0;
        blk_busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = rd_ptr_q + PTR_W'(i);
            if (CNT_W'(i) < count_q) begin
                if (slot_q[slot].waddr == snp_waddr) begin
                    snp_hit  = 1'b1;
                    snp_data = slot_q[slot].data;
                end
                if (same_block(slot_q[slot].waddr, snp_waddr, OFF_W)) begin
                    blk_busy = 1'b1;
                end
            end
        end
    end

    // R5: no store is lost to an overflow
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R5: the drain never pulls from an empty buffer
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R7: a word match always implies its block is occupied
    a_r7_snoop_in_block: assert property (@(posedge clk) disable iff (rst)
        snp_hit |-> blk_busy);

endmodule

// File: rtl/wtc_refill_fsm.sv
module wtc_refill_fsm
    import wtc_pkg::*;
#(
    parameter int BLK_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          miss,
    input  logic                          port_free,
    input  logic                          mem_ready,
    output fill_state_t                   state,
    output logic [$clog2(BLK_WORDS)-1:0]  word_cnt,
    output logic                          rd_req,
    output logic                          fill_we,
    output logic                          fill_begin,
    output logic                          fill_done
);

    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(BLK_WORDS - 1);

    fill_state_t state_q, state_n;
    logic [OFF_W-1:0] cnt_q;

    assign state    = state_q;
    assign word_cnt = cnt_q;
    assign rd_req   = (state_q == FS_FILL);
    assign fill_we  = rd_req && mem_ready;
    assign fill_done = fill_we && (cnt_q == LAST);
    assign fill_begin = (state_q != FS_FILL) && (state_n == FS_FILL);

    always_comb begin
        state_n = state_q;
        case (state_q)
            FS_IDLE: begin
                if (miss) begin
                    state_n = port_free ? FS_FILL : FS_DRAIN;
                end
            end
            FS_DRAIN: begin
                if (port_free) begin
                    state_n = FS_FILL;
                end
            end
            FS_FILL: begin
                if (fill_done) begin
                    state_n = FS_IDLE;
                end
            end
            default: state_n = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if (fill_begin) begin
                cnt_q <= '0;
            end else if (fill_we) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: every refill starts at word 0 of the block
    a_r4_fill_from_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_FILL && $past(state_q) != FS_FILL) |-> (cnt_q == '0));

    // R4: a refill ends only after the last word arrived
    a_r4_fill_complete: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_IDLE && $past(state_q) == FS_FILL) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/wtc_cache_ctrl.sv
module wtc_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int LINES     = 8,
    parameter int WB_DEPTH  = 4,
    parameter int BLK_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ready
);

    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = WADDR_W - OFF_W - IDX_W;

    // Address fields
    waddr_t            req_waddr;
    logic [OFF_W-1:0]  req_word;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;

    assign req_waddr = word_of(cpu_addr);
    assign req_word  = req_waddr[OFF_W-1:0];
    assign req_idx   = req_waddr[OFF_W +: IDX_W];
    assign req_tag   = req_waddr[WADDR_W-1 -: TAG_W];

    // Internal nets
    logic        lk_hit;
    word_t       lk_data;
    logic        snp_hit;
    word_t       snp_data;
    logic        blk_busy;
    wb_entry_t   wb_head;
    logic        wb_empty;
    logic        wb_full;
    logic        wb_pop;
    logic        store_acc;
    logic        store_hit_wr;
    logic        load_ok;
    logic        miss;
    logic        port_free;
    fill_state_t fsm_state;
    logic [OFF_W-1:0] fill_cnt;
    logic        rd_req;
    logic        fill_we;
    logic        fill_begin;
    logic        fill_done;
    logic        ls_wr_en;
    logic [OFF_W-1:0] ls_wr_word;
    word_t       ls_wr_data;
    wb_entry_t   push_entry;

    // Requester side decisions
    assign store_acc    = cpu_req && cpu_we && (fsm_state == FS_IDLE) && !wb_full;
    assign store_hit_wr = store_acc && lk_hit;
    assign load_ok      = cpu_req && !cpu_we && (fsm_state == FS_IDLE) && (lk_hit || snp_hit);
    assign miss         = cpu_req && !cpu_we && !lk_hit && !snp_hit;
    assign cpu_stall    = cpu_req && !(load_ok || store_acc);
    assign cpu_rdata    = snp_hit ? snp_data : lk_data;

    assign push_entry = '{waddr: req_waddr, data: cpu_wdata};

    // Line store write port: refill words take precedence
    assign ls_wr_en   = fill_we || store_hit_wr;
    assign ls_wr_word = fill_we ? fill_cnt : req_word;
    assign ls_wr_data = fill_we ? mem_rdata : cpu_wdata;

    // Memory port mux
    always_comb begin
        mem_req   = rd_req || !wb_empty;
        mem_we    = !rd_req && !wb_empty;
        mem_addr  = rd_req ? {req_tag, req_idx, fill_cnt} : wb_head.waddr;
        mem_wdata = mem_we ? wb_head.data : '0;
    end

    assign wb_pop    = mem_we && mem_ready;
    assign port_free = !blk_busy && (wb_empty || wb_pop);

    wtc_line_store #(
        .LINES     (LINES),
        .BLK_WORDS (BLK_WORDS),
        .TAG_W     (TAG_W)
    ) u_lines (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (req_idx),
        .lk_word (req_word),
        .lk_tag  (req_tag),
        .lk_hit  (lk_hit),
        .lk_data (lk_data),
        .wr_en   (ls_wr_en),
        .wr_idx  (req_idx),
        .wr_word (ls_wr_word),
        .wr_data (ls_wr_data),
        .inv_en  (fill_begin),
        .val_en  (fill_done),
        .ln_idx  (req_idx),
        .val_tag (req_tag)
    );

    wtc_write_buffer #(
        .DEPTH (WB_DEPTH),
        .OFF_W (OFF_W)
    ) u_wbuf (
        .clk        (clk),
        .rst        (rst),
        .push       (store_acc),
        .push_entry (push_entry),
        .pop        (wb_pop),
        .head       (wb_head),
        .empty      (wb_empty),
        .full       (wb_full),
        .snp_waddr  (req_waddr),
        .snp_hit    (snp_hit),
        .snp_data   (snp_data),
        .blk_busy   (blk_busy)
    );

    wtc_refill_fsm #(
        .BLK_WORDS (BLK_WORDS)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .miss       (miss),
        .port_free  (port_free),
        .mem_ready  (mem_ready),
        .state      (fsm_state),
        .word_cnt   (fill_cnt),
        .rd_req     (rd_req),
        .fill_we    (fill_we),
        .fill_begin (fill_begin),
        .fill_done  (fill_done)
    );

    // R2: a valid tag match in the idle state never stalls
    a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && fsm_state == FS_IDLE && lk_hit) |-> !cpu_stall);

    // R3: while a refill is waited for or running, the requester is held
    a_r3_busy_holds_cpu: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && fsm_state != FS_IDLE) |-> cpu_stall);

    // R6: a store facing a full buffer is held
    a_r6_full_stalls: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && wb_full) |-> cpu_stall);

    // R9: no refill read while the buffer still owns part of the block
    a_r9_no_stale_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !blk_busy);

    // R11: a pending memory request is held unchanged
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R10: no memory traffic straight out of reset
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !mem_req);

endmodule

// File: tb/wtc_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wtc_cache_ctrl_tb_top;
    import wtc_pkg::*;

    localparam int LINES     = 8;
    localparam int WB_DEPTH  = 4;
    localparam int BLK_WORDS = 4;
    localparam int MEMW      = 256;

    logic               clk = 1'b0;
    logic               rst;
    logic               cpu_req;
    logic               cpu_we;
    logic [ADDR_W-1:0]  cpu_addr;
    logic [DATA_W-1:0]  cpu_wdata;
    logic [DATA_W-1:0]  cpu_rdata;
    logic               cpu_stall;
    logic               mem_req;
    logic               mem_we;
    logic [WADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0]  mem_wdata;
    logic [DATA_W-1:0]  mem_rdata;
    logic               mem_ready;

    always #2 clk = ~clk;

    wtc_cache_ctrl #(
        .LINES     (LINES),
        .WB_DEPTH  (WB_DEPTH),
        .BLK_WORDS (BLK_WORDS)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    word_t  mem_arr [MEMW];
    word_t  ref_mem [MEMW];
    waddr_t st_q [$];
    word_t  sd_q [$];
    int     checks = 0;
    int     fails  = 0;
    int     ready_mode = 0;
    int     rd_seq = 0;
    logic   hold_pend = 1'b0;
    waddr_t hold_addr;
    logic   hold_we;

    function automatic word_t init_val(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    assign mem_rdata = mem_arr[mem_addr[7:0]];

    always @(negedge clk) begin
        mem_ready <= (ready_mode == 1) || (ready_mode == 2 && ($urandom % 4) != 0);
    end

    // Memory model and port monitor
    always @(posedge clk) begin
        if (rst) begin
            hold_pend = 1'b0;
            rd_seq    = 0;
        end else begin
            if (hold_pend) begin
                chk(mem_req && mem_addr == hold_addr && mem_we == hold_we,
                    "R11 held request", {2'b0, mem_addr}, {2'b0, hold_addr});
            end
            hold_pend = mem_req && !mem_ready;
            hold_addr = mem_addr;
            hold_we   = mem_we;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    if (st_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected write", {2'b0, mem_addr}, 32'hFFFF_FFFF);
                    end else begin
                        chk(mem_addr == st_q[0] && mem_wdata == sd_q[0],
                            "R5 write order/data", mem_wdata, sd_q[0]);
                        void'(st_q.pop_front());
                        void'(sd_q.pop_front());
                    end
                    mem_arr[mem_addr[7:0]] = mem_wdata;
                end else begin
                    bit stale;
                    stale = 1'b0;
                    chk(int'(mem_addr[1:0]) == rd_seq, "R4 refill word order",
                        32'(mem_addr[1:0]), 32'(rd_seq));
                    rd_seq = (rd_seq + 1) % BLK_WORDS;
                    for (int k = 0; k < st_q.size(); k++) begin
                        if (st_q[k][WADDR_W-1:2] == mem_addr[WADDR_W-1:2]) stale = 1'b1;
                    end
                    chk(!stale, "R9 refill while block pending", 32'(stale), 32'd0);
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] addr, input word_t wd,
                          output word_t rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall && stalls < 5000) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        if (we) begin
            ref_mem[addr[9:2]] = wd;
            st_q.push_back(addr[31:2]);
            sd_q.push_back(wd);
        end
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic load_chk(input logic [31:0] addr, input string req, input int want_stall);
        word_t rd;
        int st;
        access(1'b0, addr, '0, rd, st);
        chk(rd == ref_mem[addr[9:2]], {req, " load data"}, rd, ref_mem[addr[9:2]]);
        if (want_stall == 0) chk(st == 0, {req, " no stall"}, 32'(st), 32'd0);
        if (want_stall == 1) chk(st > 0, {req, " stall"}, 32'(st), 32'd1);
    endtask

    task automatic store_do(input logic [31:0] addr, input word_t wd, input string req, input int want_stall);
        word_t rd;
        int st;
        access(1'b1, addr, wd, rd, st);
        if (want_stall == 0) chk(st == 0, {req, " store no stall"}, 32'(st), 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMW; i++) begin
            mem_arr[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        mem_ready = 1'b0;
        ready_mode = 1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!mem_req, "R10 mem_req in reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!mem_req && !cpu_stall, "R10 quiet after reset", {30'd0, mem_req, cpu_stall}, 32'd0);

        // Cold miss, then hits across the block
        load_chk(32'h000, "R10 cold line", 1);
        load_chk(32'h000, "R2", 0);
        load_chk(32'h00C, "R4 whole block", 0);
        load_chk(32'h004, "R4 whole block", 0);

        // Conflicts on index 0, independence of index 1
        load_chk(32'h080, "R1 same index other tag", 1);
        load_chk(32'h000, "R1 evicted", 1);
        load_chk(32'h010, "R1 other index", 1);
        load_chk(32'h000, "R1 line kept", 0);

        // Snooping and buffer full
        ready_mode = 0;
        idle(2);
        store_do(32'h200, 32'hAAAA_0001, "R6", 0);
        store_do(32'h200, 32'hBBBB_0002, "R6", 0);
        load_chk(32'h200, "R7 youngest buffered", 0);
        store_do(32'h204, 32'hCCCC_0003, "R6", 0);
        store_do(32'h208, 32'hDDDD_0004, "R6", 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h20C; cpu_wdata = 32'hEEEE_0005;
        #1;
        chk(cpu_stall, "R6 full buffer stalls", 32'(cpu_stall), 32'd1);
        ready_mode = 2;
        while (cpu_stall) begin @(negedge clk); #1; end
        ref_mem[8'h83] = 32'hEEEE_0005;
        st_q.push_back(30'h83);
        sd_q.push_back(32'hEEEE_0005);
        @(posedge clk); #1;
        cpu_req = 1'b0;
        ready_mode = 1;
        idle(12);
        chk(st_q.size() == 0, "R5 buffer drained", 32'(st_q.size()), 32'd0);

        // No allocation on store miss, update on store hit
        load_chk(32'h204, "R8 store miss not allocated", 1);
        store_do(32'h208, 32'h1234_5678, "R8", 0);
        idle(8);
        load_chk(32'h208, "R8 store hit updated line", 0);

        // Refill behind a pending store to the same block
        ready_mode = 0;
        idle(2);
        store_do(32'h304, 32'h600D_F00D, "R9", 0);
        ready_mode = 2;
        load_chk(32'h300, "R9 miss behind pending store", 1);
        load_chk(32'h304, "R9 refill saw drained store", 0);
        load_chk(32'h084, "R3 miss", 1);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            a = 32'($urandom % MEMW) << 2;
            if (($urandom % 3) == 0) begin
                store_do(a, $urandom, "R5", -1);
            end else begin
                load_chk(a, "R2 random", -1);
            end
            if (($urandom % 8) == 0) idle(int'($urandom % 4));
        end

        ready_mode = 1;
        idle(12);
        chk(st_q.size() == 0, "R5 final drain", 32'(st_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule